// File: doc/BRIEF.md
# Periodic Plasticity Weight Update Controller

This controller walks an array of synapses on a programmable schedule. For each synapse it reads two correlation sums, one for pre-before-post (causal) timing and one for post-before-pre (acausal) timing. It compares each sum with its own programmable threshold. The two resulting flags select one entry of a small rule table, and that entry says whether the 4-bit stored weight goes up by one, goes down by one, or stays. A weight that changes is written back in the same cycle, and that synapse's two correlation sums are cleared with a strobe. A weight that stays leaves its sums alone, so they keep accumulating until a later sweep acts on them.

The correlation sums and the weights sit outside the block behind combinational read ports that share one synapse address. The rule table, both thresholds and the sweep interval are plain configuration inputs.

Top module: `stdp_sweep_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, until a sweep starts, `busy`, `wt_we` and `clr_stb` are 0 and `syn_addr` is 0.
- R2: When `period` > N_SYN, `busy` rises exactly `period` rising clock edges after `rst` falls, and again every `period` edges after each sweep start.
- R3: A sweep holds `busy` high for exactly N_SYN cycles and presents `syn_addr` 0, 1, ..., N_SYN-1 in ascending order, one address per cycle.
- R4: A sweep in progress is never cut short. When `period` <= N_SYN+1, the next sweep starts one cycle after the previous one ends, so sweep starts are N_SYN+1 edges apart.
- R5: The causal flag is `corr_causal >= thr_causal` and the acausal flag is `corr_acausal >= thr_acausal`. The index is {acausal flag, causal flag}, and the action is `rule_tbl[2*index+1 : 2*index]`. Code 2'b01 means increment, 2'b10 means decrement, and 2'b00 and 2'b11 mean hold.
- R6: An increment writes `wt_rdata+1` with `wt_we` high in the cycle the synapse's address is presented. A weight of 15 is not incremented and not written.
- R7: A decrement writes `wt_rdata-1` in the same way. A weight of 0 is not decremented and not written.
- R8: `clr_stb` is high in exactly the cycles in which `wt_we` is high, for the synapse at `syn_addr`.
- R9: A hold action, or a saturated step, leaves the weight and both correlation sums of that synapse untouched.
- R10: `wt_we` and `clr_stb` are 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period | input | PER_W | Sweep start interval in cycles |
| thr_causal | input | ACC_W | Threshold for the causal sum |
| thr_acausal | input | ACC_W | Threshold for the acausal sum |
| rule_tbl | input | 8 | Four 2-bit actions, indexed by the flag pair |
| busy | output | 1 | A sweep is in progress |
| syn_addr | output | ADDR_W | Synapse being visited |
| corr_causal | input | ACC_W | Causal sum of the addressed synapse |
| corr_acausal | input | ACC_W | Acausal sum of the addressed synapse |
| wt_rdata | input | WT_W | Stored weight of the addressed synapse |
| wt_we | output | 1 | Weight write enable |
| wt_wdata | output | WT_W | New weight |
| clr_stb | output | 1 | Clear both sums of the addressed synapse |

## Verification
`wt_we`, `wt_wdata` and `clr_stb` are combinational from the read data. They are due in the same cycle that `syn_addr` shows the synapse, and the written weight and the cleared sums appear in the bench memories after the next rising edge. `busy` and `syn_addr` are registered, so a sweep start shows up right after the edge that `period` counts to. The bench samples every output on the falling edge and counts edges from the falling edge at which reset was released. It compares final weights and sums only after `busy` has fallen.

// File: rtl/stdp_sweep_ctrl.sv
module stdp_sweep_ctrl #(
  parameter int N_SYN = 8,
  parameter int ACC_W = 8,
  parameter int WT_W  = 4,
  parameter int PER_W = 16,
  localparam int ADDR_W = (N_SYN > 1) ? $clog2(N_SYN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  period,
  input  logic [ACC_W-1:0]  thr_causal,
  input  logic [ACC_W-1:0]  thr_acausal,
  input  logic [7:0]        rule_tbl,
  output logic              busy,
  output logic [ADDR_W-1:0] syn_addr,
  input  logic [ACC_W-1:0]  corr_causal,
  input  logic [ACC_W-1:0]  corr_acausal,
  input  logic [WT_W-1:0]   wt_rdata,
  output logic              wt_we,
  output logic [WT_W-1:0]   wt_wdata,
  output logic              clr_stb
);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(N_SYN - 1);
  localparam logic [WT_W-1:0]   WT_MAX = '1;
  localparam logic [PER_W-1:0]  CNT_MAX = '1;

  logic [PER_W-1:0] cnt;
  logic             start;
  logic [1:0]       idx;
  logic [1:0]       act;
  logic             inc, dec;

  assign start = !busy && (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= PER_W'(1);
      busy     <= 1'b0;
      syn_addr <= '0;
    end else if (start) begin
      cnt      <= PER_W'(1);
      busy     <= 1'b1;
      syn_addr <= '0;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + PER_W'(1);
      if (busy) begin
        if (syn_addr == LAST) begin
          busy     <= 1'b0;
          syn_addr <= '0;
        end else begin
          syn_addr <= syn_addr + ADDR_W'(1);
        end
      end
    end
  end

  assign idx = {corr_acausal >= thr_acausal, corr_causal >= thr_causal};
  assign act = rule_tbl[{idx, 1'b0} +: 2];

  assign inc = (act == 2'b01) && (wt_rdata != WT_MAX);
  assign dec = (act == 2'b10) && (wt_rdata != '0);

  assign wt_we    = busy && (inc || dec);
  assign clr_stb  = wt_we;
  assign wt_wdata = inc ? wt_rdata + WT_W'(1) : wt_rdata - WT_W'(1);
endmodule

// File: rtl/stdp_sweep_ctrl_chk.sv
module stdp_sweep_ctrl_chk #(
  parameter int N_SYN  = 8,
  parameter int WT_W   = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [ADDR_W-1:0] syn_addr,
  input logic [WT_W-1:0]   wt_rdata,
  input logic              wt_we,
  input logic [WT_W-1:0]   wt_wdata,
  input logic              clr_stb
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_SYN - 1);
  localparam logic [WT_W-1:0]   WMAX = '1;

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!wt_we && !clr_stb));

  a_r8_clear_in_sweep: assert property (@(posedge clk) disable iff (rst)
    clr_stb |-> busy);

  a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
    wt_we |-> ((wt_wdata == wt_rdata + WT_W'(1)) || (wt_wdata == wt_rdata - WT_W'(1))));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    wt_we |-> !((wt_rdata == WMAX) && (wt_wdata == '0)) &&
              !((wt_rdata == '0) && (wt_wdata == WMAX)));

  a_r3_first_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (syn_addr == '0));

  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (syn_addr == $past(syn_addr) + ADDR_W'(1)));

  a_r4_full_sweep: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(syn_addr) == LAST));
endmodule

bind stdp_sweep_ctrl stdp_sweep_ctrl_chk #(
  .N_SYN(N_SYN), .WT_W(WT_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/stdp_sweep_ctrl_tb.sv
module stdp_sweep_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int AW    = 3;
  localparam int ACW   = 8;
  localparam int WW    = 4;
  localparam int PW    = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [PW-1:0]  period = PW'(40);
  logic [ACW-1:0] thr_causal = '0, thr_acausal = '0;
  logic [7:0]     rule_tbl = '0;
  logic           busy, wt_we, clr_stb;
  logic [AW-1:0]  syn_addr;
  logic [ACW-1:0] corr_causal, corr_acausal;
  logic [WW-1:0]  wt_rdata, wt_wdata;

  logic [WW-1:0]  wmem [N];
  logic [ACW-1:0] cmem [N];
  logic [ACW-1:0] amem [N];
  logic [WW-1:0]  seed_w [N];
  logic [ACW-1:0] seed_c [N];
  logic [ACW-1:0] seed_a [N];

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  stdp_sweep_ctrl #(.N_SYN(N), .ACC_W(ACW), .WT_W(WW), .PER_W(PW)) u_dut (
    .clk(clk), .rst(rst), .period(period), .thr_causal(thr_causal),
    .thr_acausal(thr_acausal), .rule_tbl(rule_tbl), .busy(busy),
    .syn_addr(syn_addr), .corr_causal(corr_causal), .corr_acausal(corr_acausal),
    .wt_rdata(wt_rdata), .wt_we(wt_we), .wt_wdata(wt_wdata), .clr_stb(clr_stb)
  );

  assign wt_rdata     = wmem[syn_addr];
  assign corr_causal  = cmem[syn_addr];
  assign corr_acausal = amem[syn_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        wmem[i] <= seed_w[i];
        cmem[i] <= seed_c[i];
        amem[i] <= seed_a[i];
      end
    end else begin
      if (wt_we) wmem[syn_addr] <= wt_wdata;
      if (clr_stb) begin
        cmem[syn_addr] <= '0;
        amem[syn_addr] <= '0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [WW:0] model(input logic [WW-1:0] w, input logic [ACW-1:0] c,
      input logic [ACW-1:0] a, input logic [7:0] tbl, input logic [ACW-1:0] tc,
      input logic [ACW-1:0] ta);
    int ix;
    logic [1:0] code;
    ix = ((a >= ta) ? 2 : 0) + ((c >= tc) ? 1 : 0);
    code = tbl[ix*2 +: 2];
    if (code == 2'b01 && w != 4'd15) return {1'b1, w + 4'd1};
    if (code == 2'b10 && w != 4'd0)  return {1'b1, w - 4'd1};
    return {1'b0, w};
  endfunction

  task automatic t_reset_state();
    for (int i = 0; i < N; i++) begin
      seed_w[i] = 4'd3; seed_c[i] = 8'd99; seed_a[i] = 8'd99;
    end
    rule_tbl = 8'h55;
    period = PW'(40);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0, "R1 busy in reset", busy, 0);
    check(wt_we == 0 && clr_stb == 0, "R1 strobes in reset", wt_we + clr_stb, 0);
    check(syn_addr == 0, "R1 addr in reset", syn_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && wt_we == 0, "R1 quiet after reset", busy + wt_we, 0);
  endtask

  task automatic t_interval();
    int n, first, gap, writes;
    period = PW'(20);
    rule_tbl = 8'h00;
    do_reset();
    n = 0;
    while (!busy) begin @(negedge clk); n++; end
    check(n == 20, "R2 first start edges", n, 20);
    first = n;
    for (int k = 0; k < N; k++) begin
      check(busy == 1 && syn_addr == AW'(k), "R3 sweep address", syn_addr, k);
      @(negedge clk); n++;
    end
    check(busy == 0, "R3 sweep length", busy, 0);
    writes = 0;
    while (!busy) begin
      if (wt_we || clr_stb) writes++;
      @(negedge clk); n++;
    end
    check(writes == 0, "R10 no strobes while idle", writes, 0);
    gap = n - first;
    check(gap == 20, "R2 start interval", gap, 20);
  endtask

  task automatic t_back_to_back();
    int n, s1, s2;
    period = PW'(3);
    do_reset();
    n = 0;
    while (!busy) begin @(negedge clk); n++; end
    check(n == 3, "R2 short first start", n, 3);
    s1 = n;
    while (busy) begin @(negedge clk); n++; end
    check(n - s1 == N, "R4 sweep not cut short", n - s1, N);
    while (!busy) begin @(negedge clk); n++; end
    s2 = n;
    check(s2 - s1 == N + 1, "R4 back-to-back interval", s2 - s1, N + 1);
  endtask

  task automatic t_rules(input logic [7:0] tbl, input logic [ACW-1:0] tc,
                         input logic [ACW-1:0] ta, input string tag);
    int writes, expw;
    logic [WW:0] r;
    period = PW'(40);
    rule_tbl = tbl; thr_causal = tc; thr_acausal = ta;
    do_reset();
    writes = 0;
    while (!busy) @(negedge clk);
    while (busy) begin
      if (wt_we) writes++;
      check(wt_we == clr_stb, "R8 clear with write", clr_stb, wt_we);
      @(negedge clk);
    end
    expw = 0;
    for (int i = 0; i < N; i++) begin
      r = model(seed_w[i], seed_c[i], seed_a[i], tbl, tc, ta);
      if (r[WW]) expw++;
      check(wmem[i] == r[WW-1:0], {tag, " R5 R6 R7 weight"}, wmem[i], r[WW-1:0]);
      if (r[WW])
        check(cmem[i] == 0 && amem[i] == 0, {tag, " R8 sums cleared"},
              cmem[i] + amem[i], 0);
      else
        check(cmem[i] == seed_c[i] && amem[i] == seed_a[i], {tag, " R9 sums kept"},
              cmem[i], seed_c[i]);
    end
    check(writes == expw, {tag, " R6 write count"}, writes, expw);
  endtask

  task automatic load(input int i, input int w, input int c, input int a);
    seed_w[i] = WW'(w); seed_c[i] = ACW'(c); seed_a[i] = ACW'(a);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_interval();
    t_back_to_back();
    load(0, 5, 20, 0);  load(1, 5, 0, 20);  load(2, 15, 30, 0); load(3, 0, 0, 30);
    load(4, 7, 16, 15); load(5, 7, 15, 15); load(6, 9, 40, 40); load(7, 14, 17, 3);
    t_rules(8'h24, 8'd16, 8'd16, "A");
    load(0, 0, 0, 0);   load(1, 15, 0, 0);  load(2, 8, 10, 0);  load(3, 0, 10, 0);
    load(4, 6, 9, 50);  load(5, 6, 9, 49); load(6, 4, 200, 90); load(7, 1, 11, 60);
    t_rules(8'hD9, 8'd10, 8'd50, "B");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule